// File: doc/BRIEF.md
# Bit-Serial BCD Adder-Subtractor

This block adds or subtracts two decimal numbers that arrive one bit per clock. Each decimal digit is four bits in weight order 1, 2, 4, 8, and the least significant digit comes first. A number cycle is `DIGITS` digits long (16 by default). A strobe on `start_i` marks the first bit of a cycle, and the add/subtract choice is taken from `sub_i` on that same clock. The block stops taking bits after the last digit, so a fresh strobe is needed for every operation. A new strobe may come on the clock right after the last input bit.

The datapath is a binary operand adder followed by a serial decimal-correction adder. When subtracting, the B bit is inverted and a carry of 1 is forced into the first bit. The tens carry is latched at each digit boundary and becomes the carry-in of the next digit. In add mode that carry means the digit sum reached ten, and 6 is added to the held digit. In subtract mode a missing carry means a borrow, and 10 is added as 9 plus a forced carry. When there is no borrow, 15 plus a forced carry is added, which leaves the digit unchanged. Because of this, subtraction takes no more cycles than addition.

Each corrected digit comes out one digit time after it went in, as a serial stream and then as a registered parallel digit. At the end of the result, one-cycle flags report the decimal overflow or borrow and whether every result digit was zero. A divide loop can use the borrow to decide when to stop.

Top module: `bcd_serial_addsub`

## Requirements
- R1: Under reset and until the first strobe, `sum_o`, `digit_o`, `digit_stb_o`, `done_o`, `borrow_o` and `zero_o` are all 0.
- R2: Add mode (`sub_i`=0 at the strobe): if the strobe is in cycle c, bit j (j=0 is weight 1) of decimal digit d of A+B appears on `sum_o` in cycle c+4d+4+j. Outside such result windows `sum_o` is 0.
- R3: Subtract mode (`sub_i`=1 at the strobe): `sum_o` carries A−B with the same timing. A negative result is given as its ten's complement over `DIGITS` digits.
- R4: `digit_stb_o` is high for exactly one cycle, c+4d+8, for each digit d. In that cycle `digit_o` holds that corrected digit (bit 0 = weight 1).
- R5: `done_o` pulses in cycle c+4·DIGITS+4, which is also the strobe cycle of the last digit. From then on `borrow_o` shows the carry out of the top digit in add mode, or the final borrow (A<B) in subtract mode. Both flags hold until the next `done_o`.
- R6: `zero_o` becomes 1 at `done_o` exactly when every result digit is 0, and holds until the next `done_o`.
- R7: A strobe in the cycle right after the last input bit starts a new operation. The tail of the previous result still comes out without a gap.
- R8: `sub_i` is ignored on every cycle except the strobe cycle.
- R9: While no operation is in progress, `a_i`, `b_i` and `sub_i` have no effect on any output.
- R10: Every result digit is valid BCD (0..9), including digit sums of 10 to 19, all-nines operands and borrow chains across many digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Marks bit 0 of digit 0 of a new operation |
| sub_i | input | 1 | 1 = subtract (A−B), sampled at the strobe |
| a_i | input | 1 | Serial operand A |
| b_i | input | 1 | Serial operand B |
| sum_o | output | 1 | Serial corrected result |
| digit_o | output | 4 | Last completed result digit |
| digit_stb_o | output | 1 | Pulse: `digit_o` updated |
| done_o | output | 1 | Pulse: last digit emitted, flags updated |
| borrow_o | output | 1 | Add overflow or subtract borrow |
| zero_o | output | 1 | All result digits were zero |

## Verification
On every cycle, the assertions check that each emitted digit is legal BCD, that digit strobes are single pulses, that `done_o` coincides with a digit strobe, and that the flags only change at `done_o`. The bench covers what depends on values and timing. A reference model compares every serial bit, every parallel digit and both flags against decimal arithmetic over directed corners and random 15-digit operands, and it records the exact cycle each result is due. Back-to-back operations, toggling `sub_i` during an operation and toggling the inputs while idle can only be shown by those scenarios.

// File: rtl/bcd_serial_addsub.sv
module bcd_serial_addsub #(
  parameter int DIGITS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       sub_i,
  input  logic       a_i,
  input  logic       b_i,
  output logic       sum_o,
  output logic [3:0] digit_o,
  output logic       digit_stb_o,
  output logic       done_o,
  output logic       borrow_o,
  output logic       zero_o
);
  localparam int DW = (DIGITS > 1) ? $clog2(DIGITS) : 1;

  // operand adder stage
  logic          run, m_sub, cdig, tc;
  logic [1:0]    ibit;
  logic [DW-1:0] idig;
  logic [2:0]    lo;

  wire          act      = start_i | run;
  wire          cur_sub  = start_i ? sub_i : m_sub;
  wire [1:0]    pb       = start_i ? 2'd0 : ibit;
  wire [DW-1:0] pd       = start_i ? '0 : idig;
  wire          bx       = b_i ^ cur_sub;
  wire          cin      = start_i ? sub_i : ((pb == 2'd0) ? tc : cdig);
  wire          s        = a_i ^ bx ^ cin;
  wire          co       = (a_i & bx) | (cin & (a_i ^ bx));
  wire          tc_now   = co | (~cur_sub & s & (lo[2] | lo[1]));
  wire          fix      = cur_sub ? ~tc_now : tc_now;
  wire          dig_end  = act && (pb == 2'd3);
  wire          last_dig = (pd == DW'(DIGITS - 1));

  // correction stage
  logic [3:0] hold, kq;
  logic [2:0] olo;
  logic [1:0] obit;
  logic       kc, hfirst, hlast, fcq, ovalid, nc, zacc;

  wire nin     = (obit == 2'd0) ? kc : nc;
  wire hb      = hold[obit];
  wire kb      = kq[obit];
  assign sum_o = ovalid & (hb ^ kb ^ nin);
  wire nco     = (hb & kb) | (nin & (hb ^ kb));
  wire zprev   = (hfirst && obit == 2'd0) ? 1'b0 : zacc;
  wire out_end = ovalid && (obit == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; m_sub <= 1'b0; cdig <= 1'b0; tc <= 1'b0;
      ibit <= '0; idig <= '0; lo <= '0;
    end else if (act) begin
      if (start_i) m_sub <= sub_i;
      ibit <= pb + 2'd1;
      cdig <= co;
      if (pb != 2'd3) lo[pb] <= s;
      if (dig_end) begin
        tc   <= tc_now;
        idig <= pd + 1'b1;
        run  <= ~last_dig;
      end else begin
        idig <= pd;
        run  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0; kq <= '0; olo <= '0; obit <= '0;
      kc <= 1'b0; hfirst <= 1'b0; hlast <= 1'b0; fcq <= 1'b0;
      ovalid <= 1'b0; nc <= 1'b0; zacc <= 1'b0;
      digit_o <= '0; digit_stb_o <= 1'b0; done_o <= 1'b0;
      borrow_o <= 1'b0; zero_o <= 1'b0;
    end else begin
      digit_stb_o <= out_end;
      done_o      <= out_end & hlast;
      if (ovalid) begin
        obit <= obit + 2'd1;
        nc   <= nco;
        zacc <= zprev | sum_o;
        if (obit != 2'd3) olo[obit] <= sum_o;
      end
      if (out_end) begin
        digit_o <= {sum_o, olo};
        ovalid  <= 1'b0;
        if (hlast) begin
          zero_o   <= ~(zprev | sum_o);
          borrow_o <= kc ? ~fcq : fcq;
        end
      end
      if (dig_end) begin
        hold   <= {s, lo};
        kq     <= cur_sub ? (fix ? 4'b1001 : 4'b1111) : (fix ? 4'b0110 : 4'b0000);
        kc     <= cur_sub;
        hfirst <= (pd == '0);
        hlast  <= last_dig;
        fcq    <= tc_now;
        ovalid <= 1'b1;
        obit   <= 2'd0;
      end
    end
  end

  assert_digit_bcd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    digit_stb_o |-> (digit_o <= 4'd9));
  assert_stb_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    digit_stb_o |=> !digit_stb_o);
  assert_done_on_stb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> digit_stb_o);
  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(borrow_o) && $stable(zero_o)));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: tb/test_bcd_serial_addsub.sv
module test_bcd_serial_addsub;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, sub_i = 1'b0, a_i = 1'b0, b_i = 1'b0;
  logic sum_o, digit_stb_o, done_o, borrow_o, zero_o;
  logic [3:0] digit_o;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  int opa[ND], opb[ND];

  bit       exp_sum[int];
  string    sum_req[int];
  bit       exp_stb[int];
  int       exp_dig[int];
  bit       exp_done[int];
  bit       exp_zero[int];
  bit       exp_brw[int];

  bcd_serial_addsub #(.DIGITS(ND)) i_bcd_serial_addsub (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sub_i(sub_i), .a_i(a_i), .b_i(b_i),
    .sum_o(sum_o), .digit_o(digit_o), .digit_stb_o(digit_stb_o), .done_o(done_o),
    .borrow_o(borrow_o), .zero_o(zero_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s cycle=%0d actual=%0d expected=%0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic check_cycle();
    bit es, eb, ed;
    string rq;
    es = exp_sum.exists(cyc) ? exp_sum[cyc] : 1'b0;
    rq = sum_req.exists(cyc) ? sum_req[cyc] : "R9";
    chk(sum_o == es, rq, "sum_o", int'(sum_o), int'(es));
    eb = exp_stb.exists(cyc);
    chk(digit_stb_o == eb, "R4", "digit_stb_o", int'(digit_stb_o), int'(eb));
    if (eb) chk(int'(digit_o) == exp_dig[cyc], "R4", "digit_o", int'(digit_o), exp_dig[cyc]);
    ed = exp_done.exists(cyc);
    chk(done_o == ed, "R5", "done_o", int'(done_o), int'(ed));
    if (ed) begin
      chk(borrow_o == exp_brw[cyc], "R5", "borrow_o", int'(borrow_o), int'(exp_brw[cyc]));
      chk(zero_o == exp_zero[cyc], "R6", "zero_o", int'(zero_o), int'(exp_zero[cyc]));
    end
  endtask

  task automatic step(input bit st, input bit sb, input bit a, input bit b);
    @(negedge clk);
    check_cycle();
    start_i = st; sub_i = sb; a_i = a; b_i = b;
    cyc++;
  endtask

  task automatic idle(input int n, input bit toggle);
    for (int i = 0; i < n; i++)
      if (toggle) step(1'b0, 1'($urandom), 1'($urandom), 1'($urandom));
      else step(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // reference: decimal add / ten's complement subtract, then schedule expected events
  task automatic run_op(input bit sb, input bit wig, input string tag);
    int res[ND];
    int cr, t, c0;
    bit allz;
    cr = 0; allz = 1;
    for (int d = 0; d < ND; d++) begin
      if (!sb) begin
        t = opa[d] + opb[d] + cr;
        if (t >= 10) begin t -= 10; cr = 1; end else cr = 0;
      end else begin
        t = opa[d] - opb[d] - cr;
        if (t < 0) begin t += 10; cr = 1; end else cr = 0;
      end
      res[d] = t;
      if (t != 0) allz = 0;
    end
    c0 = cyc;
    for (int d = 0; d < ND; d++) begin
      for (int j = 0; j < 4; j++) begin
        exp_sum[c0 + 4*d + 4 + j] = res[d][j];
        sum_req[c0 + 4*d + 4 + j] = tag;
      end
      exp_stb[c0 + 4*d + 8] = 1'b1;
      exp_dig[c0 + 4*d + 8] = res[d];
    end
    exp_done[c0 + 4*ND + 4] = 1'b1;
    exp_brw[c0 + 4*ND + 4]  = cr[0];
    exp_zero[c0 + 4*ND + 4] = allz;
    for (int d = 0; d < ND; d++)
      for (int j = 0; j < 4; j++)
        step((d == 0 && j == 0), ((d == 0 && j == 0) ? sb : (wig ? 1'($urandom) : sb)),
             opa[d][j], opb[d][j]);
  endtask

  task automatic rand_ops(input int n, input int maxgap, input string tag);
    for (int k = 0; k < n; k++) begin
      for (int d = 0; d < ND; d++) begin
        opa[d] = (d == ND-1) ? 0 : $urandom_range(0, 9);
        opb[d] = (d == ND-1) ? 0 : $urandom_range(0, 9);
      end
      run_op(1'($urandom), 1'b0, tag);
      if (maxgap > 0) idle($urandom_range(0, maxgap), 1'b1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(sum_o == 0 && digit_stb_o == 0 && done_o == 0, "R1", "outputs in reset",
        int'({sum_o, digit_stb_o, done_o}), 0);
    chk(digit_o == 0 && borrow_o == 0 && zero_o == 0, "R1", "flags in reset",
        int'({digit_o, borrow_o, zero_o}), 0);
    rst_n = 1'b1;
    idle(2, 1'b0);
    // R9: inputs toggling while idle
    idle(12, 1'b1);
    // R2: plain add
    for (int d = 0; d < ND; d++) begin opa[d] = (d < 9) ? d + 1 : 0; opb[d] = (d < 9) ? 9 - d : 0; end
    run_op(1'b0, 1'b0, "R2");
    idle(8, 1'b0);
    // R10: all-nines add, carries chain through every digit
    for (int d = 0; d < ND; d++) begin opa[d] = (d < 15) ? 9 : 0; opb[d] = (d < 15) ? 9 : 0; end
    run_op(1'b0, 1'b0, "R10");
    idle(8, 1'b1);
    // R10/R5/R6: full overflow to zero
    for (int d = 0; d < ND; d++) begin opa[d] = 9; opb[d] = (d == 0) ? 1 : 0; end
    run_op(1'b0, 1'b0, "R10");
    idle(8, 1'b0);
    // R3: subtract, A > B
    for (int d = 0; d < ND; d++) begin opa[d] = (d < 6) ? 7 : 0; opb[d] = (d < 5) ? d : 0; end
    run_op(1'b1, 1'b0, "R3");
    idle(6, 1'b0);
    // R3/R5: subtract, A < B, long borrow chain
    for (int d = 0; d < ND; d++) begin opa[d] = 0; opb[d] = (d == 0) ? 1 : 0; end
    run_op(1'b1, 1'b0, "R3");
    idle(6, 1'b0);
    // R6: subtract equal operands
    for (int d = 0; d < ND; d++) begin opa[d] = (d * 3) % 10; opb[d] = (d * 3) % 10; end
    run_op(1'b1, 1'b0, "R6");
    // R7: back-to-back operations with no gap
    rand_ops(4, 0, "R7");
    idle(8, 1'b0);
    // R8: sub_i toggled during the operation
    for (int k = 0; k < 3; k++) begin
      for (int d = 0; d < ND; d++) begin opa[d] = $urandom_range(0, 9); opb[d] = $urandom_range(0, 9); end
      run_op(k[0], 1'b1, "R8");
    end
    idle(8, 1'b1);
    // random 15-digit operands with idle gaps
    rand_ops(25, 5, "R2");
    idle(10, 1'b1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule